// File: doc/BRIEF.md
# Hardware Page Table Walker

This block resolves a translation miss. It takes a virtual page number and the page number of the root table, then walks a two-level radix page table in memory. Each level holds 32-bit entries. A directory entry points to the next table and a leaf entry holds the final physical page number and its permission flags. The table reads go to a memory-read port that stands for the second-level cache, so the first-level data cache is never used for walks. The block returns either the leaf translation or a fault.

Two walks can be in progress at the same time. Each one lives in its own slot, and the slot index is the tag on the memory channel. Responses can come back in any order. A four-entry, fully associative cache of directory entries lets a walk that hits go straight to the leaf read. Entries that are not valid are never placed in that cache. A walk that finds an invalid entry starts once more from the root, and reports a fault only when the second pass also finds an invalid entry. When a leaf's accessed flag is clear, the walker writes the entry back with the flag set.

Top module: `ptw_top`

## Requirements
- R1: After reset, `walk_req_ready` is 1 and both `mem_req_valid` and `walk_rsp_valid` are 0.
- R2: A walk that misses the cache first reads the directory entry at `{root, vpn[19:10], 2'b00}`. It then reads the leaf at `{dir[31:12], vpn[9:0], 2'b00}`. It responds with `ppn = leaf[31:12]`, `flags = leaf[11:0]` (bit 5 set) and `fault = 0`.
- R3: If the leaf's accessed bit (bit 5) is clear, the walker issues exactly one write to the leaf address with data `leaf | 32'h20`. If that bit is already set, no write is issued.
- R4: A walk whose `vpn[19:10]` matches a cached directory entry issues only the leaf read.
- R5: A directory entry with bit 0 (valid) clear is never cached. Once that entry is made valid in memory, the next walk uses it with no flush needed.
- R6: When an entry with bit 0 clear is found, the walker reads again from the root directory, without using the cache. It reports `fault = 1` with `ppn = 0` and `flags = 0` only if the second pass also finds an invalid entry. If the second pass finds the entry valid, it returns the translation.
- R7: A one-cycle pulse on `pdc_flush` empties the directory cache. The next walk then reads the directory again.
- R8: Two walks can be outstanding at once. Memory responses are routed by `mem_rsp_id`, whatever order they arrive in, and each result carries the `walk_rsp_vpn` of its own walk.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and its address, ID and write flag do not change.
- R10: The cache replaces entries in round-robin order, and a flush resets the pointer to entry 0. After a flush, fills for five distinct top indices evict the first of them, while the second still hits.
- R11: `walk_req_ready` is 0 while both walk slots are busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_req_valid | input | 1 | New walk request |
| walk_req_ready | output | 1 | A walk slot is free |
| walk_req_vpn | input | 20 | Virtual page number to translate |
| walk_req_root | input | 20 | Page number of the root directory |
| walk_rsp_valid | output | 1 | Walk result valid this cycle |
| walk_rsp_vpn | output | 20 | Virtual page number of the finished walk |
| walk_rsp_fault | output | 1 | Confirmed translation fault |
| walk_rsp_ppn | output | 20 | Physical page number |
| walk_rsp_flags | output | 12 | Leaf flags, accessed bit included |
| pdc_flush | input | 1 | Clear the directory-entry cache |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_id | output | 1 | Walk slot issuing the request |
| mem_req_we | output | 1 | 1 = accessed-flag write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_id | input | 1 | Slot the read data belongs to |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
A cold walk with the accessed flag clear shows the order and addresses of the two reads and the write-back. A second walk under the same directory shows that a cache hit skips one level and that an entry with the flag already set is not written. Invalid directory and leaf entries are tried three ways: entries that stay invalid (fault after two passes), an entry that memory turns valid between the passes (translation, no fault), and an invalid entry that is later made valid without a flush (shows nothing was cached). Two walks are run with the responses deliberately reordered, a stalled memory port is checked for a stable request, and five distinct top indices show the eviction order.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W  = 32;
  localparam int IDX_W = 10;
  localparam int PG_W  = IDX_W + 2;
  localparam int PN_W  = VA_W - PG_W;
  localparam int VPN_W = 2 * IDX_W;
  localparam int PTE_W = 32;
  localparam int V_BIT = 0;
  localparam int A_BIT = 5;

  typedef enum logic [2:0] {
    WS_IDLE, WS_LOOKUP, WS_READ_DIR, WS_READ_LEAF, WS_MARK, WS_REWALK, WS_DONE
  } walk_state_e;

  function automatic logic [IDX_W-1:0] top_idx(input logic [VPN_W-1:0] vpn);
    return vpn[VPN_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] low_idx(input logic [VPN_W-1:0] vpn);
    return vpn[IDX_W-1:0];
  endfunction

  function automatic logic [VA_W-1:0] entry_addr(input logic [PN_W-1:0] base,
                                                 input logic [IDX_W-1:0] idx);
    return {base, idx, 2'b00};
  endfunction

  function automatic logic pte_valid(input logic [PTE_W-1:0] pte);
    return pte[V_BIT];
  endfunction

  function automatic logic pte_accessed(input logic [PTE_W-1:0] pte);
    return pte[A_BIT];
  endfunction

  function automatic logic [PN_W-1:0] pte_pn(input logic [PTE_W-1:0] pte);
    return pte[PTE_W-1 -: PN_W];
  endfunction
endpackage

// File: rtl/ptw_pdc.sv
module ptw_pdc #(
  parameter int ENTRIES = 4,
  parameter int NLOOK   = 2,
  parameter int TAG_W   = 10,
  parameter int DATA_W  = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush_i,
  input  logic [NLOOK-1:0][TAG_W-1:0]   look_tag_i,
  output logic [NLOOK-1:0]              hit_o,
  output logic [NLOOK-1:0][DATA_W-1:0]  data_o,
  input  logic                          fill_i,
  input  logic [TAG_W-1:0]              fill_tag_i,
  input  logic [DATA_W-1:0]             fill_data_i,
  output logic                          any_valid_o
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [ENTRIES-1:0][DATA_W-1:0] data_q;
  logic [PTR_W-1:0]               ptr_q;
  logic [PTR_W-1:0]               victim;
  logic                           fill_match;

  // one associative lookup port per walk slot
  for (genvar p = 0; p < NLOOK; p++) begin : g_look
    always_comb begin
      hit_o[p]  = 1'b0;
      data_o[p] = '0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (valid_q[e] && tag_q[e] == look_tag_i[p]) begin
          hit_o[p]  = 1'b1;
          data_o[p] = data_q[e];
        end
      end
    end
  end

  // a fill whose tag is already present overwrites that entry in place
  always_comb begin
    fill_match = 1'b0;
    victim     = ptr_q;
    for (int e = 0; e < ENTRIES; e++) begin
      if (valid_q[e] && tag_q[e] == fill_tag_i) begin
        fill_match = 1'b1;
        victim     = PTR_W'(e);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      data_q  <= '0;
      ptr_q   <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (fill_i) begin
      valid_q[victim] <= 1'b1;
      tag_q[victim]   <= fill_tag_i;
      data_q[victim]  <= fill_data_i;
      if (!fill_match)
        ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assign any_valid_o = |valid_q;
endmodule

// File: rtl/ptw_walk_slot.sv
module ptw_walk_slot
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [PN_W-1:0]   root_i,
  output logic [IDX_W-1:0]  look_idx_o,
  input  logic              pdc_hit_i,
  input  logic [PN_W-1:0]   pdc_base_i,
  output logic              req_valid_o,
  output logic              req_we_o,
  output logic [VA_W-1:0]   req_addr_o,
  output logic [PTE_W-1:0]  req_wdata_o,
  input  logic              grant_i,
  input  logic              rsp_valid_i,
  input  logic [PTE_W-1:0]  rsp_data_i,
  output logic              fill_valid_o,
  output logic [IDX_W-1:0]  fill_tag_o,
  output logic [PN_W-1:0]   fill_base_o,
  output logic              idle_o,
  output logic              done_o,
  input  logic              ack_i,
  output logic              fault_o,
  output logic              rewalked_o,
  output logic [PTE_W-1:0]  leaf_o,
  output logic [VPN_W-1:0]  vpn_o
);
  walk_state_e       state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [PN_W-1:0]   root_q;
  logic [PN_W-1:0]   base_q;
  logic [PTE_W-1:0]  leaf_q;
  logic              sent_q;
  logic              rewalk_q;
  logic              fault_q;
  logic              rsp_here;

  assign rsp_here = rsp_valid_i && sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WS_IDLE;
      vpn_q    <= '0;
      root_q   <= '0;
      base_q   <= '0;
      leaf_q   <= '0;
      sent_q   <= 1'b0;
      rewalk_q <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      case (state_q)
        WS_IDLE: if (start_i) begin
          vpn_q    <= vpn_i;
          root_q   <= root_i;
          rewalk_q <= 1'b0;
          fault_q  <= 1'b0;
          sent_q   <= 1'b0;
          state_q  <= WS_LOOKUP;
        end
        WS_LOOKUP: if (pdc_hit_i) begin
          base_q  <= pdc_base_i;
          state_q <= WS_READ_LEAF;
        end else begin
          state_q <= WS_READ_DIR;
        end
        WS_READ_DIR: begin
          if (grant_i) sent_q <= 1'b1;
          if (rsp_here) begin
            sent_q <= 1'b0;
            if (pte_valid(rsp_data_i)) begin
              base_q  <= pte_pn(rsp_data_i);
              state_q <= WS_READ_LEAF;
            end else if (rewalk_q) begin
              fault_q <= 1'b1;
              state_q <= WS_DONE;
            end else begin
              state_q <= WS_REWALK;
            end
          end
        end
        WS_READ_LEAF: begin
          if (grant_i) sent_q <= 1'b1;
          if (rsp_here) begin
            sent_q <= 1'b0;
            if (pte_valid(rsp_data_i)) begin
              leaf_q  <= rsp_data_i;
              state_q <= pte_accessed(rsp_data_i) ? WS_DONE : WS_MARK;
            end else if (rewalk_q) begin
              fault_q <= 1'b1;
              state_q <= WS_DONE;
            end else begin
              state_q <= WS_REWALK;
            end
          end
        end
        WS_MARK: if (grant_i) begin
          leaf_q[A_BIT] <= 1'b1;
          state_q       <= WS_DONE;
        end
        WS_REWALK: begin
          rewalk_q <= 1'b1;
          state_q  <= WS_READ_DIR;
        end
        WS_DONE: if (ack_i) state_q <= WS_IDLE;
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  always_comb begin
    req_valid_o = 1'b0;
    req_we_o    = 1'b0;
    req_addr_o  = '0;
    req_wdata_o = '0;
    case (state_q)
      WS_READ_DIR: begin
        req_valid_o = !sent_q;
        req_addr_o  = entry_addr(root_q, top_idx(vpn_q));
      end
      WS_READ_LEAF: begin
        req_valid_o = !sent_q;
        req_addr_o  = entry_addr(base_q, low_idx(vpn_q));
      end
      WS_MARK: begin
        req_valid_o = 1'b1;
        req_we_o    = 1'b1;
        req_addr_o  = entry_addr(base_q, low_idx(vpn_q));
        req_wdata_o = leaf_q | (PTE_W'(1) << A_BIT);
      end
      default: ;
    endcase
  end

  assign look_idx_o   = top_idx(vpn_q);
  assign fill_valid_o = (state_q == WS_READ_DIR) && rsp_here && pte_valid(rsp_data_i);
  assign fill_tag_o   = top_idx(vpn_q);
  assign fill_base_o  = pte_pn(rsp_data_i);
  assign idle_o       = (state_q == WS_IDLE);
  assign done_o       = (state_q == WS_DONE);
  assign fault_o      = fault_q;
  assign rewalked_o   = rewalk_q;
  assign leaf_o       = leaf_q;
  assign vpn_o        = vpn_q;
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int NUM_WALKS   = 2,
  parameter int PDC_ENTRIES = 4,
  parameter int ID_W        = (NUM_WALKS > 1) ? $clog2(NUM_WALKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              walk_req_valid,
  output logic              walk_req_ready,
  input  logic [VPN_W-1:0]  walk_req_vpn,
  input  logic [PN_W-1:0]   walk_req_root,
  output logic              walk_rsp_valid,
  output logic [VPN_W-1:0]  walk_rsp_vpn,
  output logic              walk_rsp_fault,
  output logic [PN_W-1:0]   walk_rsp_ppn,
  output logic [PG_W-1:0]   walk_rsp_flags,
  input  logic              pdc_flush,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ID_W-1:0]   mem_req_id,
  output logic              mem_req_we,
  output logic [VA_W-1:0]   mem_req_addr,
  output logic [PTE_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [ID_W-1:0]   mem_rsp_id,
  input  logic [PTE_W-1:0]  mem_rsp_data
);
  logic [NUM_WALKS-1:0]             slot_start, slot_idle, slot_done, slot_ack;
  logic [NUM_WALKS-1:0]             slot_req, slot_we, slot_grant, slot_rsp;
  logic [NUM_WALKS-1:0]             slot_fill, slot_fault, slot_rewalked;
  logic [NUM_WALKS-1:0]             look_hit;
  logic [NUM_WALKS-1:0][IDX_W-1:0]  look_idx, fill_tags;
  logic [NUM_WALKS-1:0][PN_W-1:0]   look_base, fill_bases;
  logic [NUM_WALKS-1:0][VA_W-1:0]   slot_addr;
  logic [NUM_WALKS-1:0][PTE_W-1:0]  slot_wdata, slot_leaf;
  logic [NUM_WALKS-1:0][VPN_W-1:0]  slot_vpn;

  // named events for the checker
  logic              fill_valid;
  logic [IDX_W-1:0]  fill_tag;
  logic [PN_W-1:0]   fill_base;
  logic              pdc_any_valid;
  logic [ID_W-1:0]   rsp_slot;
  logic [ID_W-1:0]   req_sel;
  logic              req_any, lock_q;
  logic [ID_W-1:0]   lock_id_q;

  for (genvar g = 0; g < NUM_WALKS; g++) begin : g_slot
    ptw_walk_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (slot_start[g]),
      .vpn_i       (walk_req_vpn),
      .root_i      (walk_req_root),
      .look_idx_o  (look_idx[g]),
      .pdc_hit_i   (look_hit[g]),
      .pdc_base_i  (look_base[g]),
      .req_valid_o (slot_req[g]),
      .req_we_o    (slot_we[g]),
      .req_addr_o  (slot_addr[g]),
      .req_wdata_o (slot_wdata[g]),
      .grant_i     (slot_grant[g]),
      .rsp_valid_i (slot_rsp[g]),
      .rsp_data_i  (mem_rsp_data),
      .fill_valid_o(slot_fill[g]),
      .fill_tag_o  (fill_tags[g]),
      .fill_base_o (fill_bases[g]),
      .idle_o      (slot_idle[g]),
      .done_o      (slot_done[g]),
      .ack_i       (slot_ack[g]),
      .fault_o     (slot_fault[g]),
      .rewalked_o  (slot_rewalked[g]),
      .leaf_o      (slot_leaf[g]),
      .vpn_o       (slot_vpn[g])
    );
    assign slot_rsp[g]   = mem_rsp_valid && (mem_rsp_id == ID_W'(g));
    assign slot_grant[g] = mem_req_valid && mem_req_ready && (req_sel == ID_W'(g));
  end

  ptw_pdc #(
    .ENTRIES(PDC_ENTRIES), .NLOOK(NUM_WALKS), .TAG_W(IDX_W), .DATA_W(PN_W)
  ) u_pdc (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (pdc_flush),
    .look_tag_i (look_idx),
    .hit_o      (look_hit),
    .data_o     (look_base),
    .fill_i     (fill_valid),
    .fill_tag_i (fill_tag),
    .fill_data_i(fill_base),
    .any_valid_o(pdc_any_valid)
  );

  // only one memory response per cycle, so at most one slot fills
  always_comb begin
    fill_valid = 1'b0;
    fill_tag   = '0;
    fill_base  = '0;
    for (int i = 0; i < NUM_WALKS; i++) begin
      fill_valid = fill_valid | slot_fill[i];
      fill_tag   = fill_tag  | (slot_fill[i] ? fill_tags[i]  : '0);
      fill_base  = fill_base | (slot_fill[i] ? fill_bases[i] : '0);
    end
  end

  // new walk goes to the lowest idle slot
  always_comb begin
    logic found;
    found      = 1'b0;
    slot_start = '0;
    for (int i = 0; i < NUM_WALKS; i++) begin
      if (slot_idle[i] && !found) begin
        slot_start[i] = walk_req_valid;
        found         = 1'b1;
      end
    end
    walk_req_ready = found;
  end

  // memory request arbiter, locked to its choice while stalled
  always_comb begin
    req_sel = '0;
    req_any = 1'b0;
    for (int i = 0; i < NUM_WALKS; i++) begin
      if (slot_req[i] && !req_any) begin
        req_sel = ID_W'(i);
        req_any = 1'b1;
      end
    end
    if (lock_q) req_sel = lock_id_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      lock_id_q <= '0;
    end else begin
      lock_q    <= mem_req_valid && !mem_req_ready;
      lock_id_q <= req_sel;
    end
  end

  assign mem_req_valid = req_any;
  assign mem_req_id    = req_sel;
  assign mem_req_we    = slot_we[req_sel];
  assign mem_req_addr  = slot_addr[req_sel];
  assign mem_req_wdata = slot_wdata[req_sel];

  // result port: lowest finished slot is reported and released
  always_comb begin
    logic found;
    found    = 1'b0;
    rsp_slot = '0;
    slot_ack = '0;
    for (int i = 0; i < NUM_WALKS; i++) begin
      if (slot_done[i] && !found) begin
        rsp_slot    = ID_W'(i);
        slot_ack[i] = 1'b1;
        found       = 1'b1;
      end
    end
    walk_rsp_valid = found;
  end

  assign walk_rsp_vpn   = slot_vpn[rsp_slot];
  assign walk_rsp_fault = slot_fault[rsp_slot];
  assign walk_rsp_ppn   = slot_fault[rsp_slot] ? '0 : pte_pn(slot_leaf[rsp_slot]);
  assign walk_rsp_flags = slot_fault[rsp_slot] ? '0 : slot_leaf[rsp_slot][PG_W-1:0];
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int NUM_WALKS = 2,
  parameter int ID_W      = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mem_req_valid,
  input logic                 mem_req_ready,
  input logic [ID_W-1:0]      mem_req_id,
  input logic                 mem_req_we,
  input logic [31:0]          mem_req_addr,
  input logic [31:0]          mem_req_wdata,
  input logic                 mem_rsp_valid,
  input logic [31:0]          mem_rsp_data,
  input logic                 fill_valid,
  input logic                 pdc_flush,
  input logic                 pdc_any_valid,
  input logic                 walk_rsp_valid,
  input logic                 walk_rsp_fault,
  input logic [ID_W-1:0]      rsp_slot,
  input logic [NUM_WALKS-1:0] slot_rewalked
);
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_id) && $stable(mem_req_we));

  a_r5_fill_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> mem_rsp_valid && mem_rsp_data[0]);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    pdc_flush |=> !pdc_any_valid);

  a_r6_fault_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
    walk_rsp_valid && walk_rsp_fault |-> slot_rewalked[rsp_slot]);

  a_r3_mark_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[5] && mem_req_wdata[0]);
endmodule

bind ptw_top ptw_checker #(.NUM_WALKS(NUM_WALKS), .ID_W(ID_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_id    (mem_req_id),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data),
  .fill_valid    (fill_valid),
  .pdc_flush     (pdc_flush),
  .pdc_any_valid (pdc_any_valid),
  .walk_rsp_valid(walk_rsp_valid),
  .walk_rsp_fault(walk_rsp_fault),
  .rsp_slot      (rsp_slot),
  .slot_rewalked (slot_rewalked)
);

// File: tb/tb_ptw_top.sv
module tb_ptw_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_req_valid = 1'b0;
  logic        walk_req_ready;
  logic [19:0] walk_req_vpn = '0;
  logic [19:0] walk_req_root = '0;
  logic        walk_rsp_valid;
  logic [19:0] walk_rsp_vpn;
  logic        walk_rsp_fault;
  logic [19:0] walk_rsp_ppn;
  logic [11:0] walk_rsp_flags;
  logic        pdc_flush = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [0:0]  mem_req_id;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [0:0]  mem_rsp_id = '0;
  logic [31:0] mem_rsp_data = '0;

  always #4 clk = ~clk;  // 125 MHz

  ptw_top dut (.*);

  localparam logic [19:0] ROOT = 20'h00010;

  int checks = 0;
  int fails  = 0;

  // memory model state
  logic [31:0] mem [logic [31:0]];
  logic        pend [2];
  int          pcnt [2];
  logic [31:0] pdat [2];
  int          lat = 1;
  logic        rev = 1'b0;
  logic [31:0] rd_log [16];
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [31:0] wr_addr = '0, wr_data = '0;
  logic        patch_on = 1'b0;
  int          patch_at = 0;
  logic [31:0] patch_addr = '0, patch_val = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    logic sent;
    #1;
    sent = 1'b0;
    mem_rsp_valid = 1'b0;
    for (int i = 0; i < 2; i++) begin
      if (pend[i] && pcnt[i] > 0) pcnt[i]--;
      else if (pend[i] && !sent) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_id    = 1'(i);
        mem_rsp_data  = pdat[i];
        pend[i]       = 1'b0;
        sent          = 1'b1;
      end
    end
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr] = mem_req_wdata;
        wr_cnt++;
        wr_addr = mem_req_addr;
        wr_data = mem_req_wdata;
      end else begin
        pend[mem_req_id] = 1'b1;
        pcnt[mem_req_id] = lat + ((rev && mem_req_id == 1'b0) ? 6 : 0);
        pdat[mem_req_id] = rd(mem_req_addr);
        if (rd_cnt < 16) rd_log[rd_cnt] = mem_req_addr;
        rd_cnt++;
        if (patch_on && rd_cnt == patch_at) begin
          mem[patch_addr] = patch_val;
          patch_on = 1'b0;
        end
      end
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    rd_cnt = 0;
    wr_cnt = 0;
  endtask

  task automatic issue(input logic [19:0] vpn);
    int n = 0;
    @(negedge clk);
    while (!walk_req_ready && n < 200) begin @(negedge clk); n++; end
    walk_req_valid = 1'b1;
    walk_req_vpn   = vpn;
    walk_req_root  = ROOT;
    @(negedge clk);
    walk_req_valid = 1'b0;
  endtask

  task automatic wait_rsp(output logic [19:0] vpn, output logic f,
                          output logic [19:0] ppn, output logic [11:0] fl);
    int n = 0;
    while (!walk_rsp_valid && n < 300) begin @(negedge clk); n++; end
    vpn = walk_rsp_vpn; f = walk_rsp_fault; ppn = walk_rsp_ppn; fl = walk_rsp_flags;
    if (n >= 300) check(1'b0, "timeout waiting response", 0, 1);
    @(negedge clk);
  endtask

  task automatic walk(input logic [19:0] vpn, output logic f,
                      output logic [19:0] ppn, output logic [11:0] fl);
    logic [19:0] v;
    issue(vpn);
    wait_rsp(v, f, ppn, fl);
  endtask

  task automatic t_reset();
    check(walk_req_ready == 1'b1, "R1 ready", 32'(walk_req_ready), 1);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 0);
    check(walk_rsp_valid == 1'b0, "R1 walk_rsp_valid", 32'(walk_rsp_valid), 0);
  endtask

  task automatic t_cold_walk();  // R2, R3
    logic f; logic [19:0] p; logic [11:0] fl;
    mem[32'h0001_0004] = {20'h00020, 12'h001};
    mem[32'h0002_0004] = {20'h12345, 12'h00F};
    clear_log();
    walk(20'h00401, f, p, fl);
    check(rd_cnt == 2, "R2 read count", rd_cnt, 2);
    check(rd_log[0] == 32'h0001_0004, "R2 dir address", rd_log[0], 32'h0001_0004);
    check(rd_log[1] == 32'h0002_0004, "R2 leaf address", rd_log[1], 32'h0002_0004);
    check(p == 20'h12345 && !f, "R2 ppn", 32'(p), 32'h12345);
    check(fl == 12'h02F, "R2 flags", 32'(fl), 32'h02F);
    check(wr_cnt == 1 && wr_addr == 32'h0002_0004, "R3 write addr", wr_addr, 32'h0002_0004);
    check(wr_data == 32'h1234_502F, "R3 write data", wr_data, 32'h1234_502F);
  endtask

  task automatic t_pdc_hit();  // R4, R3
    logic f; logic [19:0] p; logic [11:0] fl;
    mem[32'h0002_0008] = {20'hABCDE, 12'h023};
    clear_log();
    walk(20'h00402, f, p, fl);
    check(rd_cnt == 1 && rd_log[0] == 32'h0002_0008, "R4 leaf-only read", rd_log[0], 32'h0002_0008);
    check(p == 20'hABCDE && fl == 12'h023, "R4 translation", 32'(p), 32'hABCDE);
    check(wr_cnt == 0, "R3 no write when flag set", wr_cnt, 0);
  endtask

  task automatic t_invalid();  // R5, R6
    logic f; logic [19:0] p; logic [11:0] fl;
    clear_log();
    walk(20'h00800, f, p, fl);
    check(f == 1'b1, "R6 fault reported", 32'(f), 1);
    check(p == 20'h0 && fl == 12'h0, "R6 fault fields zero", 32'(p), 0);
    check(rd_cnt == 2 && rd_log[1] == 32'h0001_0008, "R6 second dir read", rd_cnt, 2);
    mem[32'h0001_0008] = {20'h00030, 12'h001};
    mem[32'h0003_0000] = {20'h55555, 12'h021};
    clear_log();
    walk(20'h00800, f, p, fl);
    check(!f && p == 20'h55555, "R5 made-valid entry used", 32'(p), 32'h55555);
    check(rd_cnt == 2 && rd_log[0] == 32'h0001_0008, "R5 dir read again", rd_cnt, 2);
  endtask

  task automatic t_rewalk_recovers();  // R6
    logic f; logic [19:0] p; logic [11:0] fl;
    mem[32'h0001_000C] = {20'h00040, 12'h001};
    mem[32'h0004_0000] = 32'h0;
    patch_addr = 32'h0004_0000; patch_val = {20'h77777, 12'h021};
    patch_at = 2; patch_on = 1'b1;
    clear_log();
    walk(20'h00C00, f, p, fl);
    check(!f && p == 20'h77777, "R6 rewalk finds valid", 32'(p), 32'h77777);
    check(rd_cnt == 4 && rd_log[2] == 32'h0001_000C, "R6 rewalk from root", rd_log[2], 32'h0001_000C);
  endtask

  task automatic t_flush();  // R7
    logic f; logic [19:0] p; logic [11:0] fl;
    @(negedge clk); pdc_flush = 1'b1;
    @(negedge clk); pdc_flush = 1'b0;
    clear_log();
    walk(20'h00401, f, p, fl);
    check(rd_cnt == 2 && rd_log[0] == 32'h0001_0004, "R7 dir read after flush", rd_cnt, 2);
    check(wr_cnt == 0 && p == 20'h12345, "R7 translation, no write", 32'(p), 32'h12345);
  endtask

  task automatic t_replace();  // R10
    logic f; logic [19:0] p; logic [11:0] fl;
    @(negedge clk); pdc_flush = 1'b1;
    @(negedge clk); pdc_flush = 1'b0;
    mem[32'h0006_0000] = {20'h11111, 12'h021};
    for (int i = 4; i <= 8; i++) begin
      mem[32'h0001_0000 + 32'(i) * 4] = {20'h00060, 12'h001};
      walk(20'(i) << 10, f, p, fl);
    end
    clear_log();
    walk(20'h01400, f, p, fl);
    check(rd_cnt == 1, "R10 second fill still cached", rd_cnt, 1);
    clear_log();
    walk(20'h01000, f, p, fl);
    check(rd_cnt == 2 && rd_log[0] == 32'h0001_0010, "R10 first fill evicted", rd_cnt, 2);
  endtask

  task automatic t_concurrent();  // R8, R11
    logic [19:0] v, p; logic f; logic [11:0] fl;
    int good = 0;
    mem[32'h0001_0024] = {20'h00070, 12'h001};
    mem[32'h0001_0028] = {20'h00080, 12'h001};
    mem[32'h0007_0000] = {20'hAAAAA, 12'h021};
    mem[32'h0008_0000] = {20'hBBBBB, 12'h021};
    rev = 1'b1; lat = 2;
    issue(20'h02400);
    issue(20'h02800);
    check(walk_req_ready == 1'b0, "R11 ready low, both busy", 32'(walk_req_ready), 0);
    for (int k = 0; k < 2; k++) begin
      wait_rsp(v, f, p, fl);
      if (v == 20'h02400 && p == 20'hAAAAA && !f) good++;
      if (v == 20'h02800 && p == 20'hBBBBB && !f) good++;
    end
    check(good == 2, "R8 results matched to walks", good, 2);
    rev = 1'b0; lat = 1;
  endtask

  task automatic t_backpressure();  // R9
    logic [19:0] v, p; logic f; logic [11:0] fl;
    logic [31:0] a0;
    mem_req_ready = 1'b0;
    issue(20'h00401);
    @(negedge clk);
    a0 = mem_req_addr;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(mem_req_valid && mem_req_addr == a0, "R9 request held", mem_req_addr, a0);
    end
    mem_req_ready = 1'b1;
    wait_rsp(v, f, p, fl);
    check(!f && p == 20'h12345, "R9 completes after stall", 32'(p), 32'h12345);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin pend[i] = 1'b0; pcnt[i] = 0; pdat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_walk();
    t_pdc_hit();
    t_invalid();
    t_rewalk_recovers();
    t_flush();
    t_replace();
    t_concurrent();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule